// File: doc/BRIEF.md
# Branch Target and Condition Resolver

This block is the execute step for branch micro-ops in a 64-bit load/store core. It is purely combinational. From one decoded branch it produces three results: the next fetch address with a taken flag, the return address with a write flag, and the new value of the loop counter with a write flag. The decode stage supplies the branch kind, the raw instruction fields, the current instruction address, the 32-bit condition register, the 64-bit counter and two 64-bit special-register operands.

There are three branch kinds. The unconditional immediate branch always redirects fetch. The conditional immediate branch and the conditional register branch redirect only when two tests both pass. The first test checks one bit of the condition register. The second test checks the counter against zero. Separate bits of the 5-bit options field enable, bypass and invert each test. Whenever the counter test is enabled, the counter also moves down by one. A 32-bit-mode input limits the zero test to the low half of the counter.

The block has no clock, no back-pressure and no handshake. A surrounding pipeline stage registers the outputs, and the inputs must be held stable for that stage's sampling edge. All outputs are valid in the same cycle as the inputs.

Top module: `brres_top`

## Requirements
- R1: Kind code 0 is the unconditional immediate branch. For this kind `nia_vld` is always 1 and `ctr_we` is always 0.
- R2: For kind 0, the target offset is the 24-bit `fld_li` sign-extended and multiplied by 4. If `fld_aa` is 1, `nia_out` equals the offset. If `fld_aa` is 0, `nia_out` is `cia` plus the offset, taken modulo 2^64.
- R3: For kinds 0, 1 and 2, `lr_we` equals `fld_lk`. When `lr_we` is 1, `lr_out` is `cia + 4` modulo 2^64.
- R4: Condition-bit index n (`fld_bi`) selects `cr_in[31-n]`. Bits `fld_bi[4:2]` pick a 4-bit field, and field f sits at `cr_in[(7-f)*4 +: 4]`. The condition test passes when `fld_bo[4]` is 1, or when the selected bit equals `fld_bo[3]`.
- R5: The counter test passes when `fld_bo[2]` is 1. Otherwise it passes when (counter is not zero) XOR `fld_bo[1]` is 1. The counter value used is `ctr_in` before any decrement.
- R6: When `mode32` is 1, only `ctr_in[31:0]` is compared with zero.
- R7: For kinds 1 and 2, `nia_vld` is the AND of the condition test and the counter test.
- R8: For kind 1, the offset is the 14-bit `fld_bd` sign-extended and multiplied by 4. The absolute/relative rule of R2 applies.
- R9: For kind 2, the target is `spr_a` when `fld_xo[9]` is 1 and `fld_xo[5]` is 0. Otherwise the target is `spr_b`. In both cases bits [1:0] of `nia_out` are forced to 0.
- R10: For kinds 1 and 2 with `fld_bo[2]` equal to 0, `ctr_we` is 1 and `ctr_out` is the full 64-bit `ctr_in - 1`, even in 32-bit mode. Otherwise `ctr_we` is 0.
- R11: Kind code 3 is reserved. For this kind `nia_vld`, `lr_we` and `ctr_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 2 | Branch kind: 0 unconditional immediate, 1 conditional immediate, 2 conditional register, 3 reserved |
| fld_li | input | 24 | Long immediate word offset |
| fld_bd | input | 14 | Short immediate word offset |
| fld_aa | input | 1 | Absolute target select |
| fld_lk | input | 1 | Link request |
| fld_bo | input | 5 | Branch options |
| fld_bi | input | 5 | Condition bit index |
| fld_xo | input | 10 | Extended opcode |
| cia | input | 64 | Current instruction address |
| cr_in | input | 32 | Condition register |
| ctr_in | input | 64 | Counter register |
| spr_a | input | 64 | First special-register operand |
| spr_b | input | 64 | Second special-register operand |
| mode32 | input | 1 | 32-bit mode for the counter zero test |
| nia_out | output | 64 | Next instruction address |
| nia_vld | output | 1 | Branch taken |
| lr_out | output | 64 | Return address |
| lr_we | output | 1 | Return address write |
| ctr_out | output | 64 | Updated counter |
| ctr_we | output | 1 | Counter write |

## Verification
The bench builds the block with its default parameters: a 64-bit address, a 32-bit condition register, 24-bit and 14-bit immediates, and a 10-bit extended opcode. At these widths the tests can reach the top sign bits of both immediates and the 2^64 wrap of relative targets and of the return address. They also reach a counter whose low half is zero while its upper half is not, which tells the 32-bit zero test apart from the 64-bit decrement. The full 4-bit field mapping of the condition register is reachable too, so the tests probe bit indices at both ends and inside a middle field.

// File: rtl/brres_pkg.sv
package brres_pkg;
  typedef enum logic [1:0] {
    BK_UNCOND_IMM = 2'd0,
    BK_COND_IMM   = 2'd1,
    BK_COND_REG   = 2'd2,
    BK_RESERVED   = 2'd3
  } br_kind_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/brres_cond_eval.sv
module brres_cond_eval #(
  parameter int unsigned CR_W    = 32,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned BI_W    = 5
) (
  input  logic [CR_W-1:0] cr_in,
  input  logic [BI_W-1:0] bi,
  input  logic            bypass,
  input  logic            sense,
  output logic            cond_ok
);
  localparam int unsigned NFIELD = CR_W / FIELD_W;
  localparam int unsigned SEL_W  = $clog2(NFIELD);
  localparam int unsigned POS_W  = BI_W - SEL_W;

  logic [FIELD_W-1:0] fld [NFIELD];
  logic [FIELD_W-1:0] cur_fld;
  logic [FIELD_W-1:0] rev_fld;
  logic [SEL_W-1:0]   fsel;
  logic [POS_W-1:0]   bpos;

  // Field 0 is the most significant nibble.
  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    assign fld[g] = cr_in[(NFIELD-1-g)*FIELD_W +: FIELD_W];
  end

  assign fsel    = bi[BI_W-1 -: SEL_W];
  assign bpos    = bi[POS_W-1:0];
  assign cur_fld = fld[fsel];

  // Bit 0 of a field is its most significant bit.
  for (genvar k = 0; k < FIELD_W; k++) begin : g_rev
    assign rev_fld[k] = cur_fld[FIELD_W-1-k];
  end

  assign cond_ok = bypass | (rev_fld[bpos] == sense);
endmodule

// File: rtl/brres_ctr_unit.sv
module brres_ctr_unit #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32
) (
  input  logic [XLEN-1:0] ctr_in,
  input  logic            mode32,
  input  logic            bypass,
  input  logic            on_zero,
  output logic            ctr_ok,
  output logic [XLEN-1:0] ctr_next
);
  logic [XLEN-1:0] ctr_cmp;
  logic            nonzero;

  always_comb begin
    ctr_cmp = ctr_in;
    if (mode32) ctr_cmp = {{(XLEN-NARROW){1'b0}}, ctr_in[NARROW-1:0]};
  end

  assign nonzero  = |ctr_cmp;
  assign ctr_ok   = bypass | (nonzero ^ on_zero);
  assign ctr_next = ctr_in - {{(XLEN-1){1'b0}}, 1'b1};
endmodule

// File: rtl/brres_target_gen.sv
module brres_target_gen
  import brres_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned LI_W = 24,
  parameter int unsigned BD_W = 14,
  parameter int unsigned XO_W = 10
) (
  input  br_kind_e        kind,
  input  logic [LI_W-1:0] li,
  input  logic [BD_W-1:0] bd,
  input  logic            aa,
  input  logic [XO_W-1:0] xo,
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] spr_a,
  input  logic [XLEN-1:0] spr_b,
  output logic [XLEN-1:0] target
);
  localparam int unsigned XO_SEL_HI = 9;
  localparam int unsigned XO_SEL_LO = 5;

  logic [XLEN-1:0] li_off, bd_off, imm_off, imm_tgt, reg_src, reg_tgt;
  logic            pick_a;

  assign li_off  = {{(XLEN-LI_W-2){li[LI_W-1]}}, li, 2'b00};
  assign bd_off  = {{(XLEN-BD_W-2){bd[BD_W-1]}}, bd, 2'b00};
  assign imm_off = (kind == BK_UNCOND_IMM) ? li_off : bd_off;
  assign imm_tgt = aa ? imm_off : (cia + imm_off);

  assign pick_a  = xo[XO_SEL_HI] & ~xo[XO_SEL_LO];
  assign reg_src = pick_a ? spr_a : spr_b;
  assign reg_tgt = {reg_src[XLEN-1:2], 2'b00};

  always_comb begin
    unique case (kind)
      BK_COND_REG: target = reg_tgt;
      BK_RESERVED: target = '0;
      default:     target = imm_tgt;
    endcase
  end
endmodule

// File: rtl/brres_top.sv
module brres_top
  import brres_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CR_W    = 32,
  parameter int unsigned LI_W    = 24,
  parameter int unsigned BD_W    = 14,
  parameter int unsigned XO_W    = 10,
  parameter int unsigned BO_W    = 5,
  parameter int unsigned BI_W    = 5
) (
  input  logic [1:0]      op_kind,
  input  logic [LI_W-1:0] fld_li,
  input  logic [BD_W-1:0] fld_bd,
  input  logic            fld_aa,
  input  logic            fld_lk,
  input  logic [BO_W-1:0] fld_bo,
  input  logic [BI_W-1:0] fld_bi,
  input  logic [XO_W-1:0] fld_xo,
  input  logic [XLEN-1:0] cia,
  input  logic [CR_W-1:0] cr_in,
  input  logic [XLEN-1:0] ctr_in,
  input  logic [XLEN-1:0] spr_a,
  input  logic [XLEN-1:0] spr_b,
  input  logic            mode32,
  output logic [XLEN-1:0] nia_out,
  output logic            nia_vld,
  output logic [XLEN-1:0] lr_out,
  output logic            lr_we,
  output logic [XLEN-1:0] ctr_out,
  output logic            ctr_we
);
  localparam int unsigned BO_COND_BYP = 4;
  localparam int unsigned BO_COND_VAL = 3;
  localparam int unsigned BO_CTR_BYP  = 2;
  localparam int unsigned BO_CTR_ZERO = 1;
  localparam int unsigned NARROW      = XLEN / 2;

  br_kind_e        kind;
  logic            is_cond, cond_ok, ctr_ok;
  logic [XLEN-1:0] ctr_next, target;

  assign kind    = br_kind_e'(op_kind);
  assign is_cond = (kind == BK_COND_IMM) || (kind == BK_COND_REG);

  brres_cond_eval #(.CR_W(CR_W), .FIELD_W(4), .BI_W(BI_W)) u_cond (
    .cr_in  (cr_in),
    .bi     (fld_bi),
    .bypass (fld_bo[BO_COND_BYP]),
    .sense  (fld_bo[BO_COND_VAL]),
    .cond_ok(cond_ok)
  );

  brres_ctr_unit #(.XLEN(XLEN), .NARROW(NARROW)) u_ctr (
    .ctr_in  (ctr_in),
    .mode32  (mode32),
    .bypass  (fld_bo[BO_CTR_BYP]),
    .on_zero (fld_bo[BO_CTR_ZERO]),
    .ctr_ok  (ctr_ok),
    .ctr_next(ctr_next)
  );

  brres_target_gen #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W), .XO_W(XO_W)) u_tgt (
    .kind  (kind),
    .li    (fld_li),
    .bd    (fld_bd),
    .aa    (fld_aa),
    .xo    (fld_xo),
    .cia   (cia),
    .spr_a (spr_a),
    .spr_b (spr_b),
    .target(target)
  );

  always_comb begin
    unique case (kind)
      BK_UNCOND_IMM: nia_vld = 1'b1;
      BK_RESERVED:   nia_vld = 1'b0;
      default:       nia_vld = cond_ok & ctr_ok;
    endcase
  end

  assign nia_out = target;
  assign lr_out  = cia + XLEN'(INSN_BYTES);
  assign lr_we   = fld_lk & (kind != BK_RESERVED);
  assign ctr_out = ctr_next;
  assign ctr_we  = is_cond & ~fld_bo[BO_CTR_BYP];
endmodule

// File: rtl/brres_chk.sv
module brres_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned CR_W = 32
) (
  input logic [1:0]      op_kind,
  input logic            fld_lk,
  input logic [4:0]      fld_bo,
  input logic [4:0]      fld_bi,
  input logic [XLEN-1:0] cia,
  input logic [CR_W-1:0] cr_in,
  input logic [XLEN-1:0] ctr_in,
  input logic            mode32,
  input logic [XLEN-1:0] nia_out,
  input logic            nia_vld,
  input logic [XLEN-1:0] lr_out,
  input logic            lr_we,
  input logic [XLEN-1:0] ctr_out,
  input logic            ctr_we
);
  logic cond_kind;
  assign cond_kind = (op_kind == 2'd1) || (op_kind == 2'd2);

  always_comb begin
    if (!$isunknown({op_kind, fld_lk, fld_bo, fld_bi, cr_in, ctr_in, cia, mode32})) begin
      if (op_kind == 2'd0)
        a_r1_uncond_always: assert (nia_vld && !ctr_we);
      if (lr_we)
        a_r3_link_value: assert (lr_out == cia + 64'd4);
      if (!fld_lk)
        a_r3_no_link: assert (!lr_we);
      if (cond_kind && nia_vld && !fld_bo[4])
        a_r4_cond_bit: assert (cr_in[31 - fld_bi] == fld_bo[3]);
      if (cond_kind && nia_vld && !fld_bo[2] && !fld_bo[1] && !mode32)
        a_r5_ctr_nonzero: assert (ctr_in != '0);
      if (op_kind == 2'd2)
        a_r9_reg_aligned: assert (nia_out[1:0] == 2'b00);
      if (ctr_we)
        a_r10_dec_value: assert (ctr_out + 64'd1 == ctr_in && !fld_bo[2]);
      if (op_kind == 2'd3)
        a_r11_reserved_quiet: assert (!nia_vld && !lr_we && !ctr_we);
    end
  end
endmodule

bind brres_top brres_chk #(.XLEN(XLEN), .CR_W(CR_W)) u_chk (
  .op_kind(op_kind), .fld_lk(fld_lk), .fld_bo(fld_bo), .fld_bi(fld_bi),
  .cia(cia), .cr_in(cr_in), .ctr_in(ctr_in), .mode32(mode32),
  .nia_out(nia_out), .nia_vld(nia_vld), .lr_out(lr_out), .lr_we(lr_we),
  .ctr_out(ctr_out), .ctr_we(ctr_we)
);

// File: tb/brres_top_tb.sv
module brres_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  op_kind;
  logic [23:0] fld_li;
  logic [13:0] fld_bd;
  logic        fld_aa, fld_lk, mode32;
  logic [4:0]  fld_bo, fld_bi;
  logic [9:0]  fld_xo;
  logic [63:0] cia, ctr_in, spr_a, spr_b;
  logic [31:0] cr_in;
  logic [63:0] nia_out, lr_out, ctr_out;
  logic        nia_vld, lr_we, ctr_we;

  int n_checks = 0;
  int n_errors = 0;

  brres_top u_dut (
    .op_kind(op_kind), .fld_li(fld_li), .fld_bd(fld_bd), .fld_aa(fld_aa),
    .fld_lk(fld_lk), .fld_bo(fld_bo), .fld_bi(fld_bi), .fld_xo(fld_xo),
    .cia(cia), .cr_in(cr_in), .ctr_in(ctr_in), .spr_a(spr_a), .spr_b(spr_b),
    .mode32(mode32), .nia_out(nia_out), .nia_vld(nia_vld), .lr_out(lr_out),
    .lr_we(lr_we), .ctr_out(ctr_out), .ctr_we(ctr_we)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    op_kind = 2'd3; fld_li = '0; fld_bd = '0; fld_aa = 1'b0; fld_lk = 1'b0;
    fld_bo = '0; fld_bi = '0; fld_xo = '0; cia = '0; cr_in = '0;
    ctr_in = '0; spr_a = '0; spr_b = '0; mode32 = 1'b0;
  endtask

  task automatic settle();
    #5;
  endtask

  task automatic t_idle();
    @(negedge clk); clear_inputs(); fld_lk = 1'b1; ctr_in = 64'd9; settle();
    chk("R11 idle nia_vld", 64'(nia_vld), 64'd0);
    chk("R11 idle lr_we", 64'(lr_we), 64'd0);
    chk("R11 idle ctr_we", 64'(ctr_we), 64'd0);
  endtask

  task automatic t_uncond();
    @(negedge clk); clear_inputs();
    op_kind = 2'd0; cia = 64'h1000; fld_li = 24'h000010; fld_lk = 1'b1;
    fld_bo = 5'b00000; ctr_in = 64'd3; settle();
    chk("R1 uncond vld", 64'(nia_vld), 64'd1);
    chk("R1 uncond no ctr", 64'(ctr_we), 64'd0);
    chk("R2 rel target", nia_out, 64'h1040);
    chk("R3 link we", 64'(lr_we), 64'd1);
    chk("R3 link value", lr_out, 64'h1004);
    @(negedge clk); fld_li = 24'hFFFFFF; fld_aa = 1'b1; fld_lk = 1'b0; settle();
    chk("R2 abs negative", nia_out, 64'hFFFF_FFFF_FFFF_FFFC);
    chk("R3 no link", 64'(lr_we), 64'd0);
    @(negedge clk); fld_li = 24'h7FFFFF; settle();
    chk("R2 abs max positive", nia_out, 64'h0000_0000_01FF_FFFC);
    @(negedge clk); fld_aa = 1'b0; fld_lk = 1'b1;
    cia = 64'hFFFF_FFFF_FFFF_FFF0; fld_li = 24'h000008; settle();
    chk("R2 rel wrap", nia_out, 64'h10);
    chk("R3 link wrap", lr_out, 64'hFFFF_FFFF_FFFF_FFF4);
    @(negedge clk); cia = 64'hFFFF_FFFF_FFFF_FFFC; settle();
    chk("R3 link wrap to zero", lr_out, 64'h0);
  endtask

  task automatic t_cond_bit();
    @(negedge clk); clear_inputs();
    op_kind = 2'd1; fld_bo = 5'b01100; cr_in = 32'h8000_0000; fld_bi = 5'd0; settle();
    chk("R4 bit0 set taken", 64'(nia_vld), 64'd1);
    @(negedge clk); fld_bi = 5'd1; settle();
    chk("R4 bit1 clear not taken", 64'(nia_vld), 64'd0);
    @(negedge clk); cr_in = 32'h0000_0001; fld_bi = 5'd31; settle();
    chk("R4 bit31 maps to lsb", 64'(nia_vld), 64'd1);
    @(negedge clk); cr_in = 32'h0004_0000; fld_bi = 5'd13; settle();
    chk("R4 field3 bit1 maps to cr18", 64'(nia_vld), 64'd1);
    @(negedge clk); fld_bi = 5'd12; settle();
    chk("R4 neighbour bit clear", 64'(nia_vld), 64'd0);
    @(negedge clk); fld_bo = 5'b00100; settle();
    chk("R4 sense zero matches", 64'(nia_vld), 64'd1);
    @(negedge clk); fld_bo = 5'b10100; fld_bi = 5'd13; settle();
    chk("R4 bypass ignores bit", 64'(nia_vld), 64'd1);
  endtask

  task automatic t_cond_imm_target();
    @(negedge clk); clear_inputs();
    op_kind = 2'd1; fld_bo = 5'b10100; cia = 64'h2000; fld_bd = 14'h3FFF; fld_lk = 1'b1; settle();
    chk("R8 rel negative", nia_out, 64'h1FFC);
    chk("R3 cond link value", lr_out, 64'h2004);
    chk("R3 cond link we", 64'(lr_we), 64'd1);
    @(negedge clk); fld_aa = 1'b1; settle();
    chk("R8 abs negative", nia_out, 64'hFFFF_FFFF_FFFF_FFFC);
    @(negedge clk); fld_bd = 14'h0005; settle();
    chk("R8 abs positive", nia_out, 64'h14);
    @(negedge clk); fld_bd = 14'h1FFF; fld_aa = 1'b0; cia = 64'h0; settle();
    chk("R8 max positive", nia_out, 64'h7FFC);
  endtask

  task automatic t_counter();
    @(negedge clk); clear_inputs();
    op_kind = 2'd1; fld_bo = 5'b10000; ctr_in = 64'd5; settle();
    chk("R5 nonzero taken", 64'(nia_vld), 64'd1);
    chk("R10 dec we", 64'(ctr_we), 64'd1);
    chk("R10 dec value", ctr_out, 64'd4);
    @(negedge clk); ctr_in = 64'd0; settle();
    chk("R5 zero not taken", 64'(nia_vld), 64'd0);
    chk("R10 dec wraps", ctr_out, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); fld_bo = 5'b10010; settle();
    chk("R5 inverted zero taken", 64'(nia_vld), 64'd1);
    @(negedge clk); ctr_in = 64'd7; settle();
    chk("R5 inverted nonzero not taken", 64'(nia_vld), 64'd0);
    @(negedge clk); fld_bo = 5'b10100; ctr_in = 64'd0; settle();
    chk("R5 bypass taken", 64'(nia_vld), 64'd1);
    chk("R10 bypass no write", 64'(ctr_we), 64'd0);
  endtask

  task automatic t_mode32();
    @(negedge clk); clear_inputs();
    op_kind = 2'd1; fld_bo = 5'b10000; ctr_in = 64'h0000_0001_0000_0000; mode32 = 1'b1; settle();
    chk("R6 low half zero", 64'(nia_vld), 64'd0);
    chk("R10 full width dec", ctr_out, 64'h0000_0000_FFFF_FFFF);
    chk("R10 mode32 write", 64'(ctr_we), 64'd1);
    @(negedge clk); mode32 = 1'b0; settle();
    chk("R6 full width nonzero", 64'(nia_vld), 64'd1);
  endtask

  task automatic t_and();
    @(negedge clk); clear_inputs();
    op_kind = 2'd1; fld_bo = 5'b00000; fld_bi = 5'd0; cr_in = 32'h0; ctr_in = 64'd3; settle();
    chk("R7 both pass", 64'(nia_vld), 64'd1);
    @(negedge clk); cr_in = 32'h8000_0000; settle();
    chk("R7 cond fails", 64'(nia_vld), 64'd0);
    @(negedge clk); cr_in = 32'h0; ctr_in = 64'd0; settle();
    chk("R7 ctr fails", 64'(nia_vld), 64'd0);
  endtask

  task automatic t_reg();
    @(negedge clk); clear_inputs();
    op_kind = 2'd2; fld_bo = 5'b10100; cia = 64'h3000; fld_lk = 1'b1;
    spr_a = 64'h1234_5677; spr_b = 64'hABCD_EF03; fld_xo = 10'h200; settle();
    chk("R9 first operand", nia_out, 64'h1234_5674);
    chk("R7 reg taken", 64'(nia_vld), 64'd1);
    chk("R3 reg link", lr_out, 64'h3004);
    @(negedge clk); fld_xo = 10'h220; settle();
    chk("R9 bit5 picks second", nia_out, 64'hABCD_EF00);
    @(negedge clk); fld_xo = 10'h000; settle();
    chk("R9 bit9 clear picks second", nia_out, 64'hABCD_EF00);
    @(negedge clk); fld_bo = 5'b10000; ctr_in = 64'd2; settle();
    chk("R10 reg dec value", ctr_out, 64'd1);
    chk("R10 reg dec we", 64'(ctr_we), 64'd1);
  endtask

  initial begin
    clear_inputs();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_uncond();
    t_cond_bit();
    t_cond_imm_target();
    t_counter();
    t_mode32();
    t_and();
    t_reg();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule